// File: doc/BRIEF.md
# Event-Flag Serial Port

This block is a byte-wide serial port that a processor reaches through a small 32-bit register bus with five word-aligned registers. Writing the data word sends its low byte on the serial output as an 8N1 frame: one start bit low, eight data bits least significant first, and one stop bit high. Each bit lasts sixteen times the programmed divisor in clock cycles. When the stop bit has gone out, a sticky transmit event is raised. A complete frame on the serial input is kept in a one-byte holding register and raises a sticky receive event. While that receive event is pending, the block takes no new byte.

Software clears the events by writing ones to their status bits. One level-sensitive interrupt line combines the two events, each gated by its own enable bit in the control word. The status word always shows the transmit-holding-empty bit set. A pass-through bit in the control word and a break bit in the debug word are stored and read back, and have no other effect.

Inside the block, bytes move over valid/ready streams. The transmit stream is ready only while the transmitter is idle. A data write made while it is busy is lost and does not stall the bus. The receive stream is ready only while no receive event is pending. A byte that completes while it is not ready is discarded, because the serial line cannot be held back.

Top module: `uevt_uart`

## Requirements
- R1: After reset, the data, divisor, control and debug words read 0. The status word reads 0x1. `ser_tx` is high and `irq` is low.
- R2: The divisor (byte offset 0x04), control (0x0C) and debug (0x10) words store all 32 written bits and read them back unchanged. Control bit 2 and debug bit 0 have no effect on the serial line.
- R3: Status (offset 0x08) bit 0 always reads 1, and no write can clear it. Bit 1 is the receive event and bit 2 is the transmit event.
- R4: A write to the data word (offset 0x00) sends bits [7:0] as start 0, data LSB first, stop 1. Each bit lasts 16×divisor cycles, using divisor bits [15:0], and a divisor of 0 acts as 1. The line idles high.
- R5: The transmit event is set in the cycle after the stop bit ends, not at the write.
- R6: A data write that arrives while a frame is still being sent is ignored, and no extra frame appears.
- R7: A received 8N1 frame is stored, and a read of the data word returns it in bits [7:0]. The receive event is set when the frame completes.
- R8: While the receive event is set, a completed frame is dropped and the stored byte stays unchanged.
- R9: A status write clears bit 1 and/or bit 2 where the written value holds a 1, and leaves the other event bit unchanged.
- R10: `irq` is high exactly when (control bit 0 AND receive event) OR (control bit 1 AND transmit event).
- R11: A low pulse on `ser_rx` that has ended by the middle of the start bit is rejected and starts no frame.
- R12: Read data appears on `bus_rdata` with `bus_rvalid` high one clock after the request. Unmapped or misaligned addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| ser_rx | input | 1 | Serial input, idle high |
| ser_tx | output | 1 | Serial output, idle high |
| irq | output | 1 | Level interrupt |

## Verification
A read result is due on the clock edge after the request, and the bench samples it on the falling edge that follows. The transmit event is due 160×divisor+1 cycles after the data write. The bench therefore reads status once well inside the stop bit, where the event must still be clear, and once after the frame has ended, where it must be set. A received byte becomes visible about 9.5 bit periods plus two synchronizer cycles after the start edge, so the bench checks it only after driving the whole stop bit. The transmit scoreboard samples each bit at its centre, so a phase error of up to half a bit period still passes while a wrong bit length or wrong order fails.

// File: rtl/uevt_pkg.sv
package uevt_pkg;
  localparam int REG_W = 32;
  localparam int BYTE_W = 8;
  localparam int OS_RATE = 16;

  localparam logic [2:0] IDX_DATA = 3'd0;
  localparam logic [2:0] IDX_DIV  = 3'd1;
  localparam logic [2:0] IDX_STAT = 3'd2;
  localparam logic [2:0] IDX_CTRL = 3'd3;
  localparam logic [2:0] IDX_DBG  = 3'd4;

  localparam int ST_THRE = 0;
  localparam int ST_RXEV = 1;
  localparam int ST_TXEV = 2;

  localparam int CT_RXIE = 0;
  localparam int CT_TXIE = 1;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uevt_tick.sv
module uevt_tick #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic             last;

  // a divisor of zero behaves as one
  assign last = (div == '0) || (cnt >= div - 1'b1);
  assign tick = last && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || last) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uevt_tx.sv
module uevt_tx
  import uevt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  div,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              ser_out,
  output logic              done
);
  localparam int OS_W = $clog2(OS_RATE);
  localparam int BC_W = 4;
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(BYTE_W + 1);

  logic            busy;
  logic            line_q;
  logic [BYTE_W:0] shreg;
  logic [OS_W-1:0] os_cnt;
  logic [BC_W-1:0] bit_cnt;
  logic            tick;
  logic            accept;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign ser_out  = line_q;

  uevt_tick #(.CNT_W(CNT_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .div  (div),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      line_q  <= 1'b1;
      shreg   <= '1;
      os_cnt  <= '0;
      bit_cnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        line_q  <= 1'b0;
        shreg   <= {1'b1, in_data};
        os_cnt  <= '0;
        bit_cnt <= '0;
      end else if (busy && tick) begin
        if (os_cnt == OS_LAST) begin
          os_cnt <= '0;
          if (bit_cnt == BIT_LAST) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            line_q <= 1'b1;
          end else begin
            line_q  <= shreg[0];
            shreg   <= {1'b1, shreg[BYTE_W:1]};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          os_cnt <= os_cnt + 1'b1;
        end
      end
    end
  end

  AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_out); // R4
  AST_TX_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && in_valid && !tick |=> $stable(shreg)); // R6
  AST_TX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
endmodule

// File: rtl/uevt_rx.sv
module uevt_rx
  import uevt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  div,
  input  logic              ser_in,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  localparam int OS_W = $clog2(OS_RATE);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);
  localparam logic [OS_W-1:0] OS_MID  = OS_W'(OS_RATE / 2 - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

  rx_state_e         state;
  logic [1:0]        sync_q;
  logic              rx_s;
  logic [OS_W-1:0]   os_cnt;
  logic [BC_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              tick;

  assign rx_s     = sync_q[1];
  assign out_data = shreg;

  uevt_tick #(.CNT_W(CNT_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state == RX_IDLE),
    .div  (div),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      os_cnt    <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          os_cnt <= '0;
          if (!rx_s) state <= RX_START;
        end
        RX_START: if (tick) begin
          if (os_cnt == OS_MID) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
            state   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (os_cnt == OS_LAST) begin
            os_cnt <= '0;
            shreg  <= {rx_s, shreg[BYTE_W-1:1]};
            if (bit_cnt == BC_LAST) state <= RX_STOP;
            else                    bit_cnt <= bit_cnt + 1'b1;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (os_cnt == OS_LAST) begin
            state     <= RX_IDLE;
            out_valid <= rx_s;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7
  AST_RX_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> state == RX_IDLE); // R7
endmodule

// File: rtl/uevt_uart.sv
module uevt_uart
  import uevt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic              ser_rx,
  output logic              ser_tx,
  output logic              irq
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0]     widx;
  logic              aligned;
  logic              hit_data, hit_div, hit_stat, hit_ctrl, hit_dbg;
  logic              wr, rd;
  logic [REG_W-1:0]  div_q, ctrl_q, dbg_q;
  logic              rx_evt, tx_evt;
  logic [BYTE_W-1:0] rxbuf;
  logic [REG_W-1:0]  rd_mux;
  logic              tx_valid, tx_ready, tx_done;
  logic              rx_valid, rx_ready;
  logic [BYTE_W-1:0] rx_data;
  logic              clr_rx, clr_tx;

  assign widx     = bus_addr[ADDR_W-1:2];
  assign aligned  = bus_addr[1:0] == 2'b00;
  assign hit_data = aligned && widx == IW'(IDX_DATA);
  assign hit_div  = aligned && widx == IW'(IDX_DIV);
  assign hit_stat = aligned && widx == IW'(IDX_STAT);
  assign hit_ctrl = aligned && widx == IW'(IDX_CTRL);
  assign hit_dbg  = aligned && widx == IW'(IDX_DBG);
  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;

  assign tx_valid = wr && hit_data;
  assign rx_ready = !rx_evt;
  assign clr_rx   = wr && hit_stat && bus_wdata[ST_RXEV];
  assign clr_tx   = wr && hit_stat && bus_wdata[ST_TXEV];

  uevt_tx #(.CNT_W(CNT_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (div_q[CNT_W-1:0]),
    .in_valid(tx_valid),
    .in_ready(tx_ready),
    .in_data (bus_wdata[BYTE_W-1:0]),
    .ser_out (ser_tx),
    .done    (tx_done)
  );

  uevt_rx #(.CNT_W(CNT_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .div      (div_q[CNT_W-1:0]),
    .ser_in   (ser_rx),
    .out_valid(rx_valid),
    .out_data (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ctrl_q <= '0;
      dbg_q  <= '0;
    end else if (wr) begin
      if (hit_div)  div_q  <= bus_wdata;
      if (hit_ctrl) ctrl_q <= bus_wdata;
      if (hit_dbg)  dbg_q  <= bus_wdata;
    end
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_evt <= 1'b0;
      tx_evt <= 1'b0;
      rxbuf  <= '0;
    end else begin
      if (rx_valid && rx_ready) begin
        rx_evt <= 1'b1;
        rxbuf  <= rx_data;
      end else if (clr_rx) begin
        rx_evt <= 1'b0;
      end
      if (tx_done)     tx_evt <= 1'b1;
      else if (clr_tx) tx_evt <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_data) rd_mux[BYTE_W-1:0] = rxbuf;
    if (hit_div)  rd_mux = div_q;
    if (hit_ctrl) rd_mux = ctrl_q;
    if (hit_dbg)  rd_mux = dbg_q;
    if (hit_stat) begin
      rd_mux[ST_THRE] = 1'b1;
      rd_mux[ST_RXEV] = rx_evt;
      rd_mux[ST_TXEV] = tx_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  assign irq = (ctrl_q[CT_RXIE] && rx_evt) || (ctrl_q[CT_TXIE] && tx_evt);

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_evt || tx_evt)); // R10
  AST_RXBUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> $stable(rxbuf)); // R8
  AST_TXEV_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_evt) |-> $past(tx_done)); // R5
  AST_STAT_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid && $past(rd && hit_stat) |-> bus_rdata[ST_THRE]); // R3
  AST_W1C_KEEP_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt && !clr_rx |=> rx_evt); // R9
endmodule

// File: tb/sim_uevt_uart.sv
module sim_uevt_uart;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_DATA = 5'h00, A_DIV = 5'h04, A_STAT = 5'h08,
                         A_CTRL = 5'h0C, A_DBG = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        ser_rx = 1'b1;
  logic        ser_tx, irq;

  int errors = 0;
  int checks = 0;
  int bit_cyc = 32;
  logic [7:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  uevt_uart u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ser_rx(ser_rx), .ser_tx(ser_tx), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R12 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  // driver: expected byte goes into the scoreboard before the write
  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    wr(A_DATA, {24'hABCDEF, b});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] b);
    @(negedge clk);
    ser_rx = 1'b0;
    idle(bit_cyc);
    for (int i = 0; i < 8; i++) begin
      ser_rx = b[i];
      idle(bit_cyc);
    end
    ser_rx = 1'b1;
    idle(bit_cyc + 4);
  endtask

  // monitor: decode frames at bit centres and compare with the queue
  initial begin
    forever begin
      logic [7:0] got;
      @(negedge ser_tx);
      idle(bit_cyc / 2);
      chk("R4 start bit", {31'd0, ser_tx}, 32'd0);
      for (int i = 0; i < 8; i++) begin
        idle(bit_cyc);
        got[i] = ser_tx;
      end
      idle(bit_cyc);
      chk("R4 stop bit", {31'd0, ser_tx}, 32'd1);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected frame: actual=0x%02h expected=none", got);
      end else begin
        chk("R4 frame data", {24'd0, got}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 ser_tx idle", {31'd0, ser_tx}, 32'd1);
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    rd_chk("R1 data", A_DATA, 32'h0);
    rd_chk("R1 div", A_DIV, 32'h0);
    rd_chk("R1 stat", A_STAT, 32'h1);
    rd_chk("R1 ctrl", A_CTRL, 32'h0);
    rd_chk("R1 dbg", A_DBG, 32'h0);
    rd_chk("R12 unmapped", 5'h14, 32'h0);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd_chk("R12 misaligned", 5'h05, 32'h0);

    // R2 full-width storage, divisor low 16 bits = 2
    wr(A_DIV, 32'hA5A5_0002);
    wr(A_CTRL, 32'hFFFF_FFF8);
    wr(A_DBG, 32'h1234_5679);
    rd_chk("R2 div", A_DIV, 32'hA5A5_0002);
    rd_chk("R2 ctrl", A_CTRL, 32'hFFFF_FFF8);
    rd_chk("R2 dbg", A_DBG, 32'h1234_5679);
    wr(A_CTRL, 32'h4);   // pass-through bit only, R2 no effect
    bit_cyc = 32;

    // R4/R5/R6 transmit
    send_byte(8'h5A);
    wr(A_DATA, 32'hC3);  // R6 ignored while busy
    rd_chk("R5 no event at write", A_STAT, 32'h1);
    idle(290);
    rd_chk("R5 no event in stop bit", A_STAT, 32'h1);
    idle(40);
    rd_chk("R5 event after stop", A_STAT, 32'h5);
    idle(400);
    chk("R6 line idle", {31'd0, ser_tx}, 32'd1);

    // R9 write-one-to-clear
    wr(A_STAT, 32'h0);
    rd_chk("R9 zero write keeps", A_STAT, 32'h5);
    wr(A_STAT, 32'h2);
    rd_chk("R9 rx-bit write keeps tx", A_STAT, 32'h5);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd_chk("R3 thre survives", A_STAT, 32'h1);

    // R10 interrupt from tx
    wr(A_CTRL, 32'h2);
    send_byte(8'h81);
    idle(360);
    chk("R10 tx irq", {31'd0, irq}, 32'd1);
    wr(A_CTRL, 32'h1);
    chk("R10 tx irq masked", {31'd0, irq}, 32'd0);
    wr(A_CTRL, 32'h2);
    chk("R10 tx irq again", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'h4);
    chk("R10 irq after clear", {31'd0, irq}, 32'd0);

    // R7 receive
    wr(A_CTRL, 32'h1);
    rx_frame(8'h3C);
    chk("R10 rx irq", {31'd0, irq}, 32'd1);
    rd_chk("R7 rx data", A_DATA, 32'h3C);
    rd_chk("R7 rx event", A_STAT, 32'h3);

    // R8 drop while pending
    rx_frame(8'hE7);
    rd_chk("R8 byte kept", A_DATA, 32'h3C);
    rd_chk("R8 event kept", A_STAT, 32'h3);
    wr(A_STAT, 32'h2);
    chk("R10 rx irq cleared", {31'd0, irq}, 32'd0);
    rd_chk("R9 rx cleared", A_STAT, 32'h1);
    rx_frame(8'hE7);
    rd_chk("R7 next byte", A_DATA, 32'hE7);
    wr(A_STAT, 32'h2);

    // R11 glitch rejection
    @(negedge clk); ser_rx = 1'b0;
    idle(3);
    ser_rx = 1'b1;
    idle(400);
    rd_chk("R11 glitch ignored", A_STAT, 32'h1);
    rx_frame(8'h01);
    rd_chk("R11 frame after glitch", A_DATA, 32'h01);

    // R4 divisor 0 acts as 1
    wr(A_CTRL, 32'h0);
    wr(A_DBG, 32'h1);    // break bit, no effect
    bit_cyc = 16;
    wr(A_DIV, 32'h0);
    send_byte(8'h96);
    idle(260);
    rd_chk("R5 event div0", A_STAT, 32'h7);

    idle(50);
    chk("R4 all frames seen", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule